// File: doc/BRIEF.md
# Memory-Access Stage with Byte Extension

This block is the memory-access stage of a small 32-bit RISC pipeline. It takes a request made of an operation code, a base register value, a 16-bit signed byte offset and store data. It forms the effective byte address by adding the sign-extended offset to the base. It then drives a word-wide data memory port that has one write-enable bit per byte lane, and for loads it returns a value ready for register writeback.

Five operations are supported: word load, word store, signed byte load, unsigned byte load and byte store. Byte lanes are numbered big-endian, so byte offset 0 within a word is bits 31:24 and byte offset 3 is bits 7:0. Word accesses must sit on an address that is a multiple of 4. Any other word address raises a one-cycle alignment fault and no memory access is made. One request is handled at a time. The memory completes an access by raising a ready signal, and the request stays on the port, unchanged, until that happens.

Top module: `lsu_unit`

## Requirements
- R1: The address on `mem_addr` equals `base` plus `offset` sign-extended to 32 bits, so a negative offset addresses below the base.
- R2: A word load (`op` = 0) issues `mem_we` = 0000 and returns all 32 bits of `mem_rdata` unchanged on `wb_data`.
- R3: A signed byte load (`op` = 2) selects the lane given by address bits 1:0. Offset 0 is bits 31:24 and offset 3 is bits 7:0. The selected byte goes in bits 7:0 of `wb_data`, and its bit 7 is copied into bits 31:8.
- R4: An unsigned byte load (`op` = 3) selects the lane in the same way as R3 and clears bits 31:8 of `wb_data`.
- R5: A word store (`op` = 1) drives `mem_we` = 1111 and puts the full `store_data` on `mem_wdata`.
- R6: A byte store (`op` = 4) drives exactly one `mem_we` bit, bit 3 minus address bits 1:0, and copies `store_data[7:0]` into every lane of `mem_wdata`. The other three bytes of that memory word keep their values.
- R7: A word load or word store whose address bits 1:0 are not 00 raises `align_fault` for one cycle, in the cycle after the request is accepted. It raises no `mem_req`, no write strobe and no `wb_valid`.
- R8: An accepted request appears on the port one cycle after acceptance. It is held stable while `mem_ready` is low, and `busy` is high for as long as it is pending. `req_valid` is ignored while `busy` is high. A load raises `wb_valid` for one cycle, in the cycle after the ready edge.
- R9: Operation codes 5, 6 and 7 are ignored: no request, no fault, no writeback.
- R10: While `rst` is high and just after it falls, `mem_req`, `mem_we`, `wb_valid`, `align_fault` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation: 0 word load, 1 word store, 2 signed byte load, 3 unsigned byte load, 4 byte store |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed byte offset |
| store_data | input | 32 | Source register for stores |
| busy | output | 1 | A request is pending on the memory port |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 32 | Effective byte address |
| mem_we | output | 4 | Byte write enables; bit 3 is lane 0 (bits 31:24) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read word, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current access |
| wb_valid | output | 1 | Writeback value valid (one cycle) |
| wb_data | output | 32 | Extended load result |
| align_fault | output | 1 | Misaligned word access (one cycle) |

## Verification
The bench aims at the corner cases: a negative offset, every byte lane for both byte-load flavours, and byte values with bit 7 set and clear. A design with a reversed lane order, or with sign and zero extension swapped, would return the wrong byte or the wrong upper bits. The bench reads each byte store back with a word load, which exposes a design that clobbers neighbouring bytes or drives the wrong strobe. It issues misaligned word loads and stores and then reads the target word, so a design that faults but still writes, or that never faults, is caught. It also inserts wait states and offers extra requests while the unit is busy, which reveals a port that does not hold its request or accepts a second request early.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [2:0] {
    OP_LDW  = 3'd0,
    OP_STW  = 3'd1,
    OP_LDBS = 3'd2,
    OP_LDBU = 3'd3,
    OP_STB  = 3'd4
  } lsu_op_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } lsu_state_e;

  typedef struct packed {
    logic valid_op;
    logic is_word;
    logic is_byte;
    logic is_load;
    logic is_store;
    logic sext;
  } lsu_dec_t;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  localparam int NB     = XLEN / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic [2:0]        op,
  input  logic [XLEN-1:0]   base,
  input  logic [OFF_W-1:0]  offset,
  output logic [XLEN-1:0]   ea,
  output lsu_dec_t          dec,
  output logic              misaligned
);
  logic [XLEN-1:0] off_ext;

  // Sign-extend the offset to the full address width before the add.
  assign off_ext = {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
  assign ea      = base + off_ext;

  always_comb begin
    dec = '0;
    unique case (op)
      OP_LDW:  begin dec.valid_op = 1'b1; dec.is_word = 1'b1; dec.is_load  = 1'b1; end
      OP_STW:  begin dec.valid_op = 1'b1; dec.is_word = 1'b1; dec.is_store = 1'b1; end
      OP_LDBS: begin dec.valid_op = 1'b1; dec.is_byte = 1'b1; dec.is_load  = 1'b1; dec.sext = 1'b1; end
      OP_LDBU: begin dec.valid_op = 1'b1; dec.is_byte = 1'b1; dec.is_load  = 1'b1; end
      OP_STB:  begin dec.valid_op = 1'b1; dec.is_byte = 1'b1; dec.is_store = 1'b1; end
      default: dec = '0;
    endcase
  end

  // Only word accesses are checked; byte accesses are always aligned.
  assign misaligned = dec.is_word && (ea[LANE_W-1:0] != '0);
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
  parameter int XLEN = 32,
  localparam int NB     = XLEN / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic              is_word,
  input  logic              is_byte,
  input  logic              is_store,
  input  logic [LANE_W-1:0] lane,
  input  logic [XLEN-1:0]   sdata,
  output logic [NB-1:0]     we,
  output logic [XLEN-1:0]   wdata
);
  // Lane i (address offset i) maps to bits XLEN-1-8i down to XLEN-8-8i.
  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam int HI = XLEN - 1 - 8 * i;
    assign we[NB-1-i]       = is_store && (is_word || (is_byte && lane == LANE_W'(i)));
    assign wdata[HI -: 8]   = is_word ? sdata[HI -: 8] : sdata[7:0];
  end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend #(
  parameter int XLEN = 32,
  localparam int NB     = XLEN / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic [XLEN-1:0]   rdata,
  input  logic [LANE_W-1:0] lane,
  input  logic              is_word,
  input  logic              sext,
  output logic [XLEN-1:0]   result
);
  logic [7:0] lanes [NB];
  logic [7:0] picked;

  for (genvar i = 0; i < NB; i++) begin : g_pick
    assign lanes[i] = rdata[XLEN-1-8*i -: 8];
  end

  assign picked = lanes[lane];

  always_comb begin
    if (is_word)   result = rdata;
    else if (sext) result = {{(XLEN-8){picked[7]}}, picked};
    else           result = {{(XLEN-8){1'b0}}, picked};
  end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  localparam int NB     = XLEN / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] offset,
  input  logic [XLEN-1:0]  store_data,
  output logic             busy,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  output logic [NB-1:0]    mem_we,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic             mem_ready,
  output logic             wb_valid,
  output logic [XLEN-1:0]  wb_data,
  output logic             align_fault
);
  lsu_state_e      state_q;
  lsu_dec_t        dec;
  logic [XLEN-1:0] ea;
  logic            misaligned;
  logic [NB-1:0]   we_c;
  logic [XLEN-1:0] wdata_c;
  logic [XLEN-1:0] ld_result;
  logic            accept;

  logic            ld_q, word_q, sext_q;
  logic [LANE_W-1:0] lane_q;

  lsu_agen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_agen (
    .op(req_op), .base(base), .offset(offset),
    .ea(ea), .dec(dec), .misaligned(misaligned)
  );

  lsu_store_lanes #(.XLEN(XLEN)) u_st (
    .is_word(dec.is_word), .is_byte(dec.is_byte), .is_store(dec.is_store),
    .lane(ea[LANE_W-1:0]), .sdata(store_data),
    .we(we_c), .wdata(wdata_c)
  );

  lsu_load_extend #(.XLEN(XLEN)) u_ld (
    .rdata(mem_rdata), .lane(lane_q), .is_word(word_q), .sext(sext_q),
    .result(ld_result)
  );

  assign accept = req_valid && (state_q == ST_IDLE);
  assign busy   = (state_q == ST_ACCESS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      mem_we      <= '0;
      mem_wdata   <= '0;
      wb_valid    <= 1'b0;
      wb_data     <= '0;
      align_fault <= 1'b0;
      ld_q        <= 1'b0;
      word_q      <= 1'b0;
      sext_q      <= 1'b0;
      lane_q      <= '0;
    end else begin
      wb_valid    <= 1'b0;
      align_fault <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && dec.valid_op) begin
            if (misaligned) begin
              align_fault <= 1'b1;
            end else begin
              state_q   <= ST_ACCESS;
              mem_req   <= 1'b1;
              mem_addr  <= ea;
              mem_we    <= we_c;
              mem_wdata <= wdata_c;
              ld_q      <= dec.is_load;
              word_q    <= dec.is_word;
              sext_q    <= dec.sext;
              lane_q    <= ea[LANE_W-1:0];
            end
          end
        end
        ST_ACCESS: begin
          if (mem_ready) begin
            state_q <= ST_IDLE;
            mem_req <= 1'b0;
            mem_we  <= '0;
            if (ld_q) begin
              wb_valid <= 1'b1;
              wb_data  <= ld_result;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            mem_req,
  input logic [XLEN-1:0] mem_addr,
  input logic [NB-1:0]   mem_we,
  input logic            mem_ready,
  input logic            wb_valid,
  input logic            align_fault
);
  AST_FULL_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we == {NB{1'b1}}) |-> mem_addr[1:0] == 2'b00);  // R5
  AST_STROBE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_we == {NB{1'b1}} || $countones(mem_we) <= 1));  // R6
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (!mem_req && mem_we == '0 && !wb_valid));  // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R8
  AST_WB_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(mem_req && mem_ready));  // R8
  AST_BUSY_MATCHES_REQ: assert property (@(posedge clk) disable iff (rst)
    busy == mem_req);  // R8
  AST_IDLE_AT_RESET: assert property (@(posedge clk)
    rst |=> (!mem_req && !wb_valid && !align_fault));  // R10
endmodule

bind lsu_unit lsu_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_ready(mem_ready), .wb_valid(wb_valid),
  .align_fault(align_fault)
);

// File: tb/sim_lsu_unit.sv
module sim_lsu_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] base = '0, store_data = '0, mem_rdata = '0;
  logic [15:0] offset = '0;
  logic        mem_ready = 1'b0;
  logic        busy, mem_req, wb_valid, align_fault;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [3:0]  mem_we;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] bmem [0:255];

  always #4 clk = ~clk;

  lsu_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .base(base),
    .offset(offset), .store_data(store_data), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .wb_valid(wb_valid),
    .wb_data(wb_data), .align_fault(align_fault)
  );

  function automatic logic [31:0] word_at(input logic [7:0] a);
    logic [7:0] w;
    w = {a[7:2], 2'b00};
    return {bmem[w], bmem[w+8'd1], bmem[w+8'd2], bmem[w+8'd3]};
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Issue one request at a negedge and follow it cycle by cycle.
  task automatic run_op(input logic [2:0] op, input logic [31:0] b, input logic [15:0] o,
                        input logic [31:0] sd, input int delay, input string tag);
    logic [31:0] ea, exp_wd, exp_res;
    logic [3:0]  exp_we;
    logic [7:0]  bt;
    bit word, valid, mis, ld, st;
    ea    = b + {{16{o[15]}}, o};
    word  = (op == 3'd0 || op == 3'd1);
    valid = (op <= 3'd4);
    mis   = word && ea[1:0] != 2'b00;
    ld    = (op == 3'd0 || op == 3'd2 || op == 3'd3);
    st    = (op == 3'd1 || op == 3'd4);
    exp_we = 4'b0000; exp_wd = '0;
    if (op == 3'd1) begin exp_we = 4'b1111; exp_wd = sd; end
    if (op == 3'd4) begin exp_we = 4'b1000 >> ea[1:0]; exp_wd = {4{sd[7:0]}}; end
    bt = bmem[ea[7:0]];
    case (op)
      3'd0:    exp_res = word_at(ea[7:0]);
      3'd2:    exp_res = {{24{bt[7]}}, bt};
      default: exp_res = {24'h0, bt};
    endcase

    req_valid = 1'b1; req_op = op; base = b; offset = o; store_data = sd;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (!valid) begin
      chk({tag, " R9 ignored op"}, {28'h0, busy, mem_req, align_fault, wb_valid}, 32'h0);
      @(negedge clk);
      chk({tag, " R9 still quiet"}, {28'h0, busy, mem_req, align_fault, wb_valid}, 32'h0);
    end else if (mis) begin
      chk({tag, " R7 fault raised"}, {29'h0, align_fault, mem_req, busy}, 32'h4);
      chk({tag, " R7 no strobe"}, {28'h0, mem_we}, 32'h0);
      @(negedge clk);
      chk({tag, " R7 fault one cycle"}, {29'h0, align_fault, wb_valid, mem_req}, 32'h0);
    end else begin
      chk({tag, " R8 req issued"}, {30'h0, mem_req, busy}, 32'h3);
      chk({tag, " R1 address"}, mem_addr, ea);
      chk({tag, " R5 R6 strobe"}, {28'h0, mem_we}, {28'h0, exp_we});
      if (st) chk({tag, " R5 R6 write data"}, mem_wdata, exp_wd);
      for (int d = 0; d < delay; d++) begin
        req_valid = 1'b1; req_op = 3'd0; base = 32'h0; offset = 16'h0;
        @(posedge clk); @(negedge clk);
        chk({tag, " R8 held while waiting"}, {mem_addr[30:0], mem_req}, {ea[30:0], 1'b1});
        chk({tag, " R8 busy ignores request"}, {28'h0, mem_we}, {28'h0, exp_we});
      end
      req_valid = 1'b0;
      mem_rdata = word_at(ea[7:0]);
      mem_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      mem_ready = 1'b0;
      mem_rdata = '0;
      if (op == 3'd1) begin
        bmem[{ea[7:2], 2'b00}]        = sd[31:24];
        bmem[{ea[7:2], 2'b00} + 8'd1] = sd[23:16];
        bmem[{ea[7:2], 2'b00} + 8'd2] = sd[15:8];
        bmem[{ea[7:2], 2'b00} + 8'd3] = sd[7:0];
      end
      if (op == 3'd4) bmem[ea[7:0]] = sd[7:0];
      chk({tag, " R8 wb_valid pulse"}, {31'h0, wb_valid}, {31'h0, ld});
      if (ld) chk({tag, " R2 R3 R4 load result"}, wb_data, exp_res);
      chk({tag, " R8 released"}, {30'h0, mem_req, busy}, 32'h0);
      @(negedge clk);
      chk({tag, " R8 wb one cycle"}, {31'h0, wb_valid}, 32'h0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 37 + 5);
    bmem[8'h50] = 8'h80; bmem[8'h51] = 8'h7F; bmem[8'h52] = 8'hC3; bmem[8'h53] = 8'h01;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {27'h0, busy, mem_req, wb_valid, align_fault, |mem_we}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 after reset", {27'h0, busy, mem_req, wb_valid, align_fault, |mem_we}, 32'h0);

    run_op(3'd0, 32'h1000_0040, 16'h0010, 32'h0, 0, "R1 R2 lw +off");
    run_op(3'd0, 32'h1000_0060, 16'hFFF8, 32'h0, 2, "R1 R2 lw -off");
    for (int l = 0; l < 4; l++) run_op(3'd2, 32'h1000_0050, 16'(l), 32'h0, l % 2, "R3 lb lane");
    for (int l = 0; l < 4; l++) run_op(3'd3, 32'h1000_0054, 16'(-4 + l), 32'h0, 1, "R4 lbu lane");
    run_op(3'd1, 32'h1000_0070, 16'h0004, 32'hDEAD_BEEF, 1, "R5 sw");
    run_op(3'd0, 32'h1000_0074, 16'h0000, 32'h0, 0, "R5 sw readback");
    for (int l = 0; l < 4; l++) begin
      run_op(3'd4, 32'h1000_0080, 16'(l), 32'h1234_5600 | 32'(8'hA0 + l), 1, "R6 sb lane");
      run_op(3'd0, 32'h1000_0080, 16'h0000, 32'h0, 0, "R6 sb readback");
    end
    run_op(3'd0, 32'h1000_0050, 16'h0002, 32'h0, 0, "R7 lw misaligned");
    run_op(3'd1, 32'h1000_0060, 16'h0001, 32'hFFFF_FFFF, 0, "R7 sw misaligned");
    run_op(3'd1, 32'h1000_0060, 16'h0003, 32'hFFFF_FFFF, 0, "R7 sw misaligned 3");
    run_op(3'd0, 32'h1000_0060, 16'h0000, 32'h0, 0, "R7 memory untouched");
    for (int k = 5; k < 8; k++) run_op(3'(k), 32'h1000_0040, 16'h0000, 32'hFFFF_FFFF, 0, "R9 op");
    run_op(3'd0, 32'h1000_0040, 16'h0000, 32'h0, 0, "R9 memory untouched");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule